// File: doc/BRIEF.md
# Serial Receive Word Pipeline

This block is the receive data path of a synchronous serial port. Bits arrive one at a time on a serial input and are qualified by a bit strobe. They pass through three stages: a shift register, then a holding buffer, then a data register that a host can read. A word moves forward only when the stage ahead of it is empty. The data register is read as two 16-bit halves. A ready flag tells a CPU or DMA agent that a word is waiting.

Words of 1 to 32 bits are accepted. While a word moves from the buffer into the data register, it can be reformatted. With companding off, it can be right-justified with zero fill, right-justified with sign extension, or left-justified. With companding on, an 8-bit mu-law or A-law code is expanded to a 16-bit linear sample. A word that finishes while the buffer is still occupied raises a sticky overrun flag.

Top module: `serial_rx_pipe`

## Requirements
- R1: After reset, `rx_ready` and `overrun` are 0 and `rd_data` reads 0 for both values of `rd_sel`.
- R2: Each cycle with `sdata_en` high and the shift stage not holding a finished word, `sdata` is shifted in, most significant bit first. A word is finished after `word_len` bits. A `word_len` of 0, or a value above 32, acts as 32.
- R3: A finished word moves to the buffer only while the buffer is empty. Until then it stays in the shift stage, and any bits strobed in during that time are ignored.
- R4: A buffered word moves to the data register only while `rx_ready` is 0. While `rx_ready` is 1, the data register and the buffer are unchanged.
- R5: `rx_ready` rises in the cycle after a word is loaded into the data register, and only then.
- R6: A read with `rd_en`=1 and `rd_sel`=0 clears `rx_ready` at that clock edge. A buffered word then moves into the data register at the next edge.
- R7: `rd_data` shows bits [31:16] of the 32-bit formatted word when `rd_sel`=1, and bits [15:0] when `rd_sel`=0. Words of up to 16 bits use only the low half in the zero-fill modes.
- R8: The upper half must be read first. If the lower half is read first while another word is buffered, the upper half is overwritten by the next word.
- R9: With `comp_mode[1]`=0, `just_mode` selects the format:
  - 2'b00 and 2'b11: right-justify with zero fill.
  - 2'b01: right-justify with sign extension from bit `word_len`-1 up to bit 31.
  - 2'b10: left-justify with zero fill. The word is aligned to the top of the low half for lengths up to 16 bits, and to bit 31 otherwise.
- R10: With `comp_mode`=2'b10, the low 8 bits are mu-law expanded. With `comp_mode`=2'b11, they are A-law expanded. The result is a left-justified 16-bit two's-complement value in the low half, and the upper half is 0. Examples: mu-law 0x80 gives 0x7D7C and mu-law 0x00 gives 0x8284; A-law 0xD5 gives 0x0008 and A-law 0xAA gives 0x7E00.
- R11: `overrun` is set when a word finishes while the buffer is full. It stays set until `ovr_clr` or reset; if a set and a clear fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sdata | input | 1 | Serial data bit |
| sdata_en | input | 1 | Bit strobe qualifying `sdata` |
| word_len | input | 6 | Word length in bits (1 to 32) |
| comp_mode | input | 2 | Companding select: 2'b10 mu-law, 2'b11 A-law, otherwise off |
| just_mode | input | 2 | Justification and fill select |
| rd_en | input | 1 | Host read strobe |
| rd_sel | input | 1 | Half select: 1 upper, 0 lower |
| ovr_clr | input | 1 | Clears the overrun flag |
| rd_data | output | 16 | Selected half of the data register |
| rx_ready | output | 1 | Data register holds an unread word |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The block has no parameters, so the bench builds the single default configuration. Every word length, format and companding law is reached through the configuration ports. A table of words covers 8-, 16-, 20-, 24- and 32-bit lengths and the out-of-range length code, under each justification mode and both expansion laws. Directed sequences fill all three stages at once to provoke an overrun, to show that bits arriving during the stall are dropped, and to show the upper half being lost when the lower half is read first.

// File: rtl/serial_rx_pipe.sv
module serial_rx_pipe (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sdata,
  input  logic        sdata_en,
  input  logic [5:0]  word_len,
  input  logic [1:0]  comp_mode,
  input  logic [1:0]  just_mode,
  input  logic        rd_en,
  input  logic        rd_sel,
  input  logic        ovr_clr,
  output logic [15:0] rd_data,
  output logic        rx_ready,
  output logic        overrun
);
  localparam int HW = 16;
  localparam int WW = 2 * HW;

  logic [WW-1:0] sh_q, buf_q, drr_q, fmt, mask;
  logic          sh_full, buf_full;
  logic [5:0]    cnt, wl;
  logic [4:0]    top;
  logic          bit_take, last, move_sb, move_bd, rd_lo;

  function automatic logic [15:0] mu_expand(input logic [7:0] c);
    logic [7:0]  u;
    logic [15:0] t;
    u = ~c;
    t = ({9'd0, u[3:0], 3'b000} + 16'h0084) << u[6:4];
    t = t - 16'h0084;
    return u[7] ? (16'h0000 - t) : t;
  endfunction

  function automatic logic [15:0] a_expand(input logic [7:0] c);
    logic [7:0]  a;
    logic [15:0] t;
    a = c ^ 8'h55;
    t = {8'd0, a[3:0], 4'd0};
    if (a[6:4] == 3'd0) t = t + 16'd8;
    else                t = (t + 16'h0108) << (a[6:4] - 3'd1);
    return a[7] ? t : (16'h0000 - t);
  endfunction

  assign wl       = (word_len == 6'd0 || word_len > 6'd32) ? 6'd32 : word_len;
  assign top      = 5'(wl - 6'd1);
  assign mask     = (wl == 6'd32) ? '1 : ((WW'(1) << wl) - WW'(1));
  assign bit_take = sdata_en && !sh_full;
  assign last     = bit_take && (cnt == wl - 6'd1);
  assign move_sb  = sh_full && !buf_full;
  assign move_bd  = buf_full && !rx_ready;
  assign rd_lo    = rd_en && !rd_sel;
  assign rd_data  = rd_sel ? drr_q[WW-1:HW] : drr_q[HW-1:0];

  always_comb begin
    if (comp_mode[1])
      fmt = {16'h0000, comp_mode[0] ? a_expand(buf_q[7:0]) : mu_expand(buf_q[7:0])};
    else begin
      case (just_mode)
        2'b01:   fmt = buf_q[top] ? (buf_q | ~mask) : buf_q;
        2'b10:   fmt = (wl <= 6'd16) ? {16'h0000, buf_q[15:0] << (6'd16 - wl)}
                                     : (buf_q << (6'd32 - wl));
        default: fmt = buf_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      buf_q    <= '0;
      drr_q    <= '0;
      cnt      <= '0;
      sh_full  <= 1'b0;
      buf_full <= 1'b0;
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (bit_take) begin
        sh_q <= {sh_q[WW-2:0], sdata};
        cnt  <= last ? 6'd0 : cnt + 6'd1;
      end
      if (last)         sh_full <= 1'b1;
      else if (move_sb) sh_full <= 1'b0;

      if (move_sb)      buf_q <= sh_q & mask;
      if (move_sb)      buf_full <= 1'b1;
      else if (move_bd) buf_full <= 1'b0;

      if (move_bd)      drr_q <= fmt;
      if (move_bd)      rx_ready <= 1'b1;
      else if (rd_lo)   rx_ready <= 1'b0;

      if (last && buf_full) overrun <= 1'b1;
      else if (ovr_clr)     overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_pipe_chk.sv
module serial_rx_pipe_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        rd_sel,
  input logic        ovr_clr,
  input logic        rx_ready,
  input logic        overrun,
  input logic        buf_full,
  input logic [31:0] buf_q,
  input logic [31:0] drr_q
);
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && !(rd_en && !rd_sel) |=> rx_ready && $stable(drr_q));

  a_r3_buffer_held: assert property (@(posedge clk) disable iff (!rst_n)
    buf_full && rx_ready |=> buf_full && $stable(buf_q));

  a_r6_low_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready && rd_en && !rd_sel |=> !rx_ready);

  a_r5_ready_from_buffer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(buf_full));

  a_r11_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);
endmodule

bind serial_rx_pipe serial_rx_pipe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_sel(rd_sel), .ovr_clr(ovr_clr),
  .rx_ready(rx_ready), .overrun(overrun), .buf_full(buf_full),
  .buf_q(buf_q), .drr_q(drr_q)
);

// File: tb/test_serial_rx_pipe.sv
module test_serial_rx_pipe;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {word_len, comp_mode, just_mode, word, expected 32-bit value}
  localparam logic [73:0] VEC [NV] = '{
    {6'd8,  2'd0, 2'd0, 32'h000000A5, 32'h000000A5},
    {6'd8,  2'd0, 2'd1, 32'h000000A5, 32'hFFFFFFA5},
    {6'd8,  2'd0, 2'd2, 32'h000000A5, 32'h0000A500},
    {6'd16, 2'd0, 2'd0, 32'h00001234, 32'h00001234},
    {6'd24, 2'd0, 2'd0, 32'h00ABCDEF, 32'h00ABCDEF},
    {6'd24, 2'd0, 2'd1, 32'h00ABCDEF, 32'hFFABCDEF},
    {6'd24, 2'd0, 2'd2, 32'h00ABCDEF, 32'hABCDEF00},
    {6'd32, 2'd0, 2'd0, 32'hDEADBEEF, 32'hDEADBEEF},
    {6'd20, 2'd0, 2'd1, 32'h0007FFFF, 32'h0007FFFF},
    {6'd0,  2'd0, 2'd0, 32'h80000001, 32'h80000001},
    {6'd8,  2'd2, 2'd0, 32'h000000FF, 32'h00000000},
    {6'd8,  2'd2, 2'd1, 32'h00000080, 32'h00007D7C},
    {6'd8,  2'd2, 2'd0, 32'h00000000, 32'h00008284},
    {6'd8,  2'd3, 2'd2, 32'h000000D5, 32'h00000008},
    {6'd8,  2'd3, 2'd0, 32'h00000055, 32'h0000FFF8},
    {6'd8,  2'd3, 2'd0, 32'h000000AA, 32'h00007E00}
  };

  logic clk = 0, rst_n = 0, sdata = 0, sdata_en = 0;
  logic [5:0] word_len = 6'd8;
  logic [1:0] comp_mode = 0, just_mode = 0;
  logic rd_en = 0, rd_sel = 0, ovr_clr = 0;
  logic [15:0] rd_data;
  logic rx_ready, overrun;
  int checks = 0, errors = 0;

  serial_rx_pipe i_serial_rx_pipe (
    .clk(clk), .rst_n(rst_n), .sdata(sdata), .sdata_en(sdata_en),
    .word_len(word_len), .comp_mode(comp_mode), .just_mode(just_mode),
    .rd_en(rd_en), .rd_sel(rd_sel), .ovr_clr(ovr_clr),
    .rd_data(rd_data), .rx_ready(rx_ready), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send_word(input int n, input logic [31:0] w);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = w[i];
      sdata_en = 1;
      @(negedge clk);
    end
    sdata_en = 0;
  endtask

  task automatic wait_ready(input string tag);
    int k = 0;
    while (!rx_ready && k < 100) begin
      @(negedge clk);
      k++;
    end
    check({tag, " ready"}, 32'(rx_ready), 32'd1);
  endtask

  task automatic read_half(input logic sel, output logic [15:0] v);
    rd_sel = sel;
    rd_en = 1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] hi, lo;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", 32'(rx_ready), 0);
    check("R1 overrun", 32'(overrun), 0);
    rd_sel = 1; #1 check("R1 upper", 32'(rd_data), 0);
    rd_sel = 0; #1 check("R1 lower", 32'(rd_data), 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R2 R7 R9 R10 table walk
    for (int v = 0; v < NV; v++) begin
      word_len  = VEC[v][73:68];
      comp_mode = VEC[v][67:66];
      just_mode = VEC[v][65:64];
      send_word((VEC[v][73:68] == 0) ? 32 : int'(VEC[v][73:68]), VEC[v][63:32]);
      wait_ready($sformatf("R5 vec%0d", v));
      read_half(1, hi);
      read_half(0, lo);
      check($sformatf("R7 R9 R10 vec%0d upper", v), 32'(hi), 32'(VEC[v][31:16]));
      check($sformatf("R7 R9 R10 vec%0d lower", v), 32'(lo), 32'(VEC[v][15:0]));
    end

    // R3 R4 R6 R11 full pipeline stall
    word_len = 8; comp_mode = 0; just_mode = 0;
    send_word(8, 32'h11);
    wait_ready("R5 stall A");
    send_word(8, 32'h22);
    repeat (3) @(negedge clk);
    check("R11 no overrun yet", 32'(overrun), 0);
    send_word(8, 32'h33);
    check("R11 overrun set", 32'(overrun), 1);
    send_word(8, 32'h44);
    rd_sel = 0; #1 check("R4 data held", 32'(rd_data), 32'h11);
    read_half(1, hi);
    read_half(0, lo);
    check("R4 word A", 32'(lo), 32'h11);
    check("R6 ready cleared", 32'(rx_ready), 0);
    @(negedge clk);
    check("R6 next transfer", 32'(rx_ready), 1);
    read_half(1, hi);
    read_half(0, lo);
    check("R3 word B", 32'(lo), 32'h22);
    wait_ready("R3 C");
    read_half(1, hi);
    read_half(0, lo);
    check("R3 word C kept", 32'(lo), 32'h33);
    repeat (20) @(negedge clk);
    check("R3 stalled bits ignored", 32'(rx_ready), 0);
    check("R11 sticky", 32'(overrun), 1);
    ovr_clr = 1;
    @(negedge clk);
    ovr_clr = 0;
    check("R11 cleared", 32'(overrun), 0);

    // R8 reading lower half first loses the upper half
    word_len = 24;
    send_word(24, 32'h123456);
    wait_ready("R8 X");
    send_word(24, 32'hABCDEF);
    repeat (3) @(negedge clk);
    read_half(0, lo);
    check("R8 lower X", 32'(lo), 32'h3456);
    wait_ready("R8 Y");
    read_half(1, hi);
    check("R8 upper overwritten", 32'(hi), 32'h00AB);
    read_half(0, lo);
    check("R8 lower Y", 32'(lo), 32'hCDEF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule